// File: doc/BRIEF.md
# Programmable Even-Ratio Clock Divider

This block takes one input clock and produces a slower clock whose period is an even multiple of the input period, chosen at run time from eight ratios between 2 and 16. The divided clock is always square: it spends the same number of input cycles high as low. It comes straight from a flip-flop, so it can feed a clock tree without combinational hazards. A companion flag tells downstream logic when the divided clock is live.

The divider is started and stopped through an active-high reset that is sampled on the input clock. Stopping is graceful: a period already under way is allowed to finish, so the tree never sees a runt pulse. Restarting is immediate unless a start-up hold-off is strapped on. In that case the first rising edge waits one whole division period. The ratio select is taken only while the divider is idle and at the start of each output period, so it may change at any time without corrupting the period in progress.

Top module: `clkdiv_even`

## Requirements
- R1: The ratio select code n (0 to 7) gives an output period of 2*(n+1) input clock cycles.
- R2: Every output period is high for exactly n+1 input cycles and then low for exactly n+1 input cycles.
- R3: While the divider is idle and the reset input is high, the output stays low and the running flag stays low.
- R4: If reset is raised while the output runs, the current period completes, including its full low half. The divider then stops with the output low and stays stopped while reset is held.
- R5: A reset pulse of a single input cycle during a running period is remembered. The divider still stops at the end of that period, and then restarts at the following edge if reset is low.
- R6: With the hold-off strap low, the first input clock edge at which the idle divider samples reset low drives the output high.
- R7: With the hold-off strap high, the output stays low for 2*(n+1) input cycles after reset is sampled low, then rises. The running flag stays low during this wait.
- R8: Reset sampled high during the hold-off wait abandons it at once with no output pulse. A later release starts a complete new wait.
- R9: A ratio select change in the middle of a period has no effect on that period. It takes effect from the next rising edge of the output.
- R10: The running flag rises with the first output rising edge and falls at the edge that stops the output. It is low whenever the output is not toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| div_rst | input | 1 | Active-high reset, sampled on clk_in, stops the divider at a period end |
| ratio_sel | input | SEL_W (3) | Ratio select, period = 2*(code+1) input cycles |
| holdoff_en | input | 1 | Static strap: delay the first rising edge by one full period |
| clk_div | output | 1 | Divided clock, registered |
| div_running | output | 1 | High while clk_div is toggling |

## Verification
Each result is due at a fixed input edge. The output rises at the first edge after reset is seen low, or ratio edges later with hold-off. It toggles every n+1 edges, and it stops at the edge that would have begun the next period. The bench changes inputs and samples outputs on the falling edge, so a value sampled there reflects exactly the rising edges seen so far. Every run-length count it compares (high samples, low samples, hold-off samples, samples until the flag drops) is therefore an exact number of input cycles with no slack. The bound checker measures the same high and low widths on every period of the run, not only those the bench inspects.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Control sequencer states.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // stopped, output low, ratio tracked from select
    ST_HOLD = 2'd1,  // start-up wait of one full period, output low
    ST_RUN  = 2'd2   // output toggling
  } div_state_e;

endpackage

// File: rtl/clkdiv_ratio_latch.sv
module clkdiv_ratio_latch #(
  parameter int SEL_W  = 3,
  localparam int HALF_W = SEL_W + 1
) (
  input  logic              clk_in,
  input  logic              load,
  input  logic [SEL_W-1:0]  ratio_sel,
  output logic [HALF_W-1:0] half_len
);

  // Half-period length in input cycles is code + 1.
  always_ff @(posedge clk_in) begin
    if (load) begin
      half_len <= {1'b0, ratio_sel} + 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_cycle_counter.sv
module clkdiv_cycle_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_in,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             at_limit
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_in) begin
    if (clear) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end

  assign at_limit = (count_q == limit);

endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
(
  input  logic clk_in,
  input  logic div_rst,
  input  logic holdoff_en,
  input  logic at_limit,
  output logic load_ratio,
  output logic cnt_clear,
  output logic full_limit,
  output logic div_out,
  output logic running
);

  div_state_e state_q, state_d;
  logic       out_q, out_d;
  logic       stop_q, stop_d;
  logic       run_q;

  always_comb begin
    state_d    = state_q;
    out_d      = out_q;
    stop_d     = stop_q;
    load_ratio = 1'b0;
    cnt_clear  = 1'b0;
    full_limit = 1'b0;
    case (state_q)
      ST_IDLE: begin
        load_ratio = 1'b1;
        cnt_clear  = 1'b1;
        out_d      = 1'b0;
        stop_d     = 1'b0;
        if (!div_rst) begin
          if (holdoff_en) begin
            state_d = ST_HOLD;
          end else begin
            state_d = ST_RUN;
            out_d   = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        full_limit = 1'b1;
        out_d      = 1'b0;
        if (div_rst) begin
          state_d   = ST_IDLE;
          cnt_clear = 1'b1;
        end else if (at_limit) begin
          state_d    = ST_RUN;
          out_d      = 1'b1;
          load_ratio = 1'b1;
          cnt_clear  = 1'b1;
        end
      end
      ST_RUN: begin
        stop_d = stop_q | div_rst;
        if (at_limit) begin
          cnt_clear = 1'b1;
          if (out_q) begin
            out_d = 1'b0;
          end else if (stop_q || div_rst) begin
            state_d = ST_IDLE;
            stop_d  = 1'b0;
          end else begin
            out_d      = 1'b1;
            load_ratio = 1'b1;
          end
        end
      end
      default: begin
        state_d   = ST_IDLE;
        out_d     = 1'b0;
        stop_d    = 1'b0;
        cnt_clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_in) begin
    state_q <= state_d;
    out_q   <= out_d;
    stop_q  <= stop_d;
    run_q   <= (state_d == ST_RUN);
  end

  assign div_out = out_q;
  assign running = run_q;

endmodule

// File: rtl/clkdiv_even.sv
module clkdiv_even #(
  parameter int SEL_W = 3
) (
  input  logic             clk_in,
  input  logic             div_rst,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             holdoff_en,
  output logic             clk_div,
  output logic             div_running
);

  localparam int HALF_W = SEL_W + 1;
  localparam int CNT_W  = HALF_W + 1;

  logic [HALF_W-1:0] half_len;
  logic [CNT_W-1:0]  half_lim;
  logic [CNT_W-1:0]  full_lim;
  logic [CNT_W-1:0]  limit;
  logic              load_ratio;
  logic              cnt_clear;
  logic              full_limit;
  logic              at_limit;

  clkdiv_ratio_latch #(.SEL_W(SEL_W)) u_ratio (
    .clk_in    (clk_in),
    .load      (load_ratio),
    .ratio_sel (ratio_sel),
    .half_len  (half_len)
  );

  // Terminal counts: half period in run, full period during hold-off.
  assign half_lim = {1'b0, half_len} - 1'b1;
  assign full_lim = {half_len, 1'b0} - 1'b1;
  assign limit    = full_limit ? full_lim : half_lim;

  clkdiv_cycle_counter #(.CNT_W(CNT_W)) u_count (
    .clk_in   (clk_in),
    .clear    (cnt_clear),
    .limit    (limit),
    .at_limit (at_limit)
  );

  clkdiv_seq u_seq (
    .clk_in     (clk_in),
    .div_rst    (div_rst),
    .holdoff_en (holdoff_en),
    .at_limit   (at_limit),
    .load_ratio (load_ratio),
    .cnt_clear  (cnt_clear),
    .full_limit (full_limit),
    .div_out    (clk_div),
    .running    (div_running)
  );

endmodule

// File: rtl/clkdiv_even_chk.sv
module clkdiv_even_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk_in,
  input logic             div_rst,
  input logic [SEL_W-1:0] ratio_sel,
  input logic             holdoff_en,
  input logic             clk_div,
  input logic             div_running
);

  localparam int HALF_W = SEL_W + 1;
  localparam int LEN_W  = SEL_W + 4;

  logic [1:0]        arm_q = 2'b00;
  logic              prev_out = 1'b0;
  logic              prev_run = 1'b0;
  logic [SEL_W-1:0]  prev_sel = '0;
  logic [HALF_W-1:0] cap_half = '0;
  logic [LEN_W-1:0]  hi_len = '0;
  logic [LEN_W-1:0]  lo_len = '0;
  logic              rst_seen_q = 1'b0;

  always_ff @(posedge clk_in) begin
    arm_q    <= {arm_q[0], arm_q[0] | div_rst};
    prev_out <= clk_div;
    prev_run <= div_running;
    prev_sel <= ratio_sel;
    if (clk_div && !prev_out) begin
      cap_half <= {1'b0, prev_sel} + 1'b1;
    end
    hi_len <= clk_div ? (prev_out ? hi_len + 1'b1 : LEN_W'(1)) : '0;
    lo_len <= !clk_div ? (!prev_out ? lo_len + 1'b1 : LEN_W'(1)) : '0;
    if (!div_running) begin
      rst_seen_q <= 1'b0;
    end else if (div_rst) begin
      rst_seen_q <= 1'b1;
    end
  end

  assert_high_width_R2: assert property (@(posedge clk_in) disable iff (!arm_q[1])
    (!clk_div && prev_out) |-> (hi_len == LEN_W'(cap_half)));

  assert_low_width_R2: assert property (@(posedge clk_in) disable iff (!arm_q[1])
    (clk_div && !prev_out && prev_run) |-> (lo_len == LEN_W'(cap_half)));

  assert_stop_boundary_R4: assert property (@(posedge clk_in) disable iff (!arm_q[1])
    $fell(div_running) |-> (!clk_div && (lo_len == LEN_W'(cap_half)) && rst_seen_q));

  assert_start_R6: assert property (@(posedge clk_in) disable iff (!arm_q[1])
    (!div_running && !div_rst && !holdoff_en) |=> (div_running && clk_div));

  assert_idle_low_R10: assert property (@(posedge clk_in) disable iff (!arm_q[1])
    !div_running |-> !clk_div);

endmodule

bind clkdiv_even clkdiv_even_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_in      (clk_in),
  .div_rst     (div_rst),
  .ratio_sel   (ratio_sel),
  .holdoff_en  (holdoff_en),
  .clk_div     (clk_div),
  .div_running (div_running)
);

// File: tb/clkdiv_even_test.sv
module clkdiv_even_test;

  logic       clk = 1'b0;
  logic       div_rst = 1'b1;
  logic [2:0] ratio_sel = 3'd0;
  logic       holdoff_en = 1'b0;
  logic       clk_div;
  logic       div_running;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkdiv_even #(.SEL_W(3)) uut (
    .clk_in      (clk),
    .div_rst     (div_rst),
    .ratio_sel   (ratio_sel),
    .holdoff_en  (holdoff_en),
    .clk_div     (clk_div),
    .div_running (div_running)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Entered on the first high sample of a period; leaves on the next one.
  task automatic measure(output int hi, output int lo);
    hi = 1;
    step();
    while (clk_div === 1'b1 && hi < 64) begin hi++; step(); end
    lo = 1;
    step();
    while (clk_div === 1'b0 && lo < 64) begin lo++; step(); end
  endtask

  task automatic start(input logic [2:0] sel, input logic ho);
    div_rst = 1'b1; ratio_sel = sel; holdoff_en = ho;
    repeat (3) step();
    div_rst = 1'b0;
    step();
  endtask

  task automatic stop_run();
    div_rst = 1'b1;
    for (int i = 0; i < 80 && div_running !== 1'b0; i++) step();
    step();
  endtask

  task automatic t_reset_state();
    int highs = 0;
    div_rst = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      if (clk_div !== 1'b0 || div_running !== 1'b0) highs++;
    end
    check(highs == 0, "R3 idle under reset", highs, 0);
  endtask

  task automatic t_ratio(input int sel);
    int hi, lo;
    start(3'(sel), 1'b0);
    check(clk_div === 1'b1, "R6 first edge after release", int'(clk_div), 1);
    check(div_running === 1'b1, "R10 flag with first rise", int'(div_running), 1);
    measure(hi, lo);
    check(hi == sel + 1, "R2 high width", hi, sel + 1);
    check(lo == sel + 1, "R2 low width", lo, sel + 1);
    measure(hi, lo);
    check(hi + lo == 2 * (sel + 1), "R1 period", hi + lo, 2 * (sel + 1));
    stop_run();
  endtask

  task automatic t_sel_change();
    int hi, lo;
    start(3'd1, 1'b0);
    ratio_sel = 3'd6;
    measure(hi, lo);
    check(hi == 2 && lo == 2, "R9 current period kept", hi * 100 + lo, 202);
    ratio_sel = 3'd3;
    measure(hi, lo);
    check(hi == 7 && lo == 7, "R9 new ratio at boundary", hi * 100 + lo, 707);
    measure(hi, lo);
    check(hi == 4 && lo == 4, "R9 second change", hi * 100 + lo, 404);
    stop_run();
  endtask

  task automatic t_reset_mid();
    int hi = 1, lo = 0, highs = 0;
    start(3'd3, 1'b0);
    div_rst = 1'b1;
    step();
    while (clk_div === 1'b1 && hi < 64) begin hi++; step(); end
    check(hi == 4, "R4 high half finishes", hi, 4);
    while (clk_div === 1'b0 && div_running === 1'b1 && lo < 64) begin lo++; step(); end
    check(lo == 4, "R4 low half finishes", lo, 4);
    check(div_running === 1'b0, "R10 flag drops at stop", int'(div_running), 0);
    for (int i = 0; i < 16; i++) begin
      if (clk_div !== 1'b0) highs++;
      step();
    end
    check(highs == 0, "R4 stays stopped", highs, 0);
  endtask

  task automatic t_reset_pulse();
    int lo = 0;
    start(3'd1, 1'b0);
    div_rst = 1'b1;
    step();
    div_rst = 1'b0;
    step();
    while (clk_div === 1'b0 && div_running === 1'b1 && lo < 64) begin lo++; step(); end
    check(lo == 2, "R5 period completes", lo, 2);
    check(div_running === 1'b0 && clk_div === 1'b0, "R5 pulse remembered",
          int'(div_running), 0);
    step();
    check(clk_div === 1'b1 && div_running === 1'b1, "R5 restart next edge",
          int'(clk_div), 1);
    stop_run();
  endtask

  task automatic t_holdoff(input int sel);
    int lo = 0, bad = 0, hi, lo2;
    start(3'(sel), 1'b1);
    while (clk_div === 1'b0 && lo < 64) begin
      if (div_running !== 1'b0) bad++;
      lo++;
      step();
    end
    check(lo == 2 * (sel + 1), "R7 hold-off length", lo, 2 * (sel + 1));
    check(bad == 0, "R7 flag low while held", bad, 0);
    check(div_running === 1'b1, "R10 flag at delayed rise", int'(div_running), 1);
    measure(hi, lo2);
    check(hi == sel + 1 && lo2 == sel + 1, "R7 period after hold-off",
          hi * 100 + lo2, (sel + 1) * 101);
    stop_run();
    holdoff_en = 1'b0;
  endtask

  task automatic t_holdoff_abort();
    int highs = 0, lo = 0;
    start(3'd3, 1'b1);
    step(); step();
    div_rst = 1'b1;
    for (int i = 0; i < 12; i++) begin
      step();
      if (clk_div !== 1'b0 || div_running !== 1'b0) highs++;
    end
    check(highs == 0, "R8 wait abandoned", highs, 0);
    div_rst = 1'b0;
    step();
    while (clk_div === 1'b0 && lo < 64) begin lo++; step(); end
    check(lo == 8, "R8 fresh full wait", lo, 8);
    stop_run();
    holdoff_en = 1'b0;
  endtask

  initial begin
    t_reset_state();
    for (int s = 0; s < 8; s++) t_ratio(s);
    t_sel_change();
    t_reset_mid();
    t_reset_pulse();
    t_holdoff(0);
    t_holdoff(4);
    t_holdoff_abort();
    t_reset_state();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule